// File: doc/BRIEF.md
# CAN Frame Serializer with Bit Stuffing

The block turns the contents of a small byte-wide transmit buffer into one complete CAN data or remote frame on a single serial output. A one-cycle start pulse captures the buffer. After that, each bit-rate tick moves the output forward by exactly one bit. The sequence is: start-of-frame, the identifier and control fields, any data bytes, the 15-bit CRC and its delimiter, the acknowledge slot and its delimiter, seven end-of-frame bits and three intermission bits. Stuff bits are inserted wherever the protocol requires them, and the CRC is computed on the fly.

Two buffer layouts are supported, chosen by the `layout_ext` input. The base layout always produces an 11-bit-identifier frame. The extended layout carries a format flag, and when that flag is set the frame uses a 29-bit identifier. The bus level is sampled during the acknowledge slot. When the frame completes, a one-cycle `done` pulse is given, together with a flag that reports whether any receiver acknowledged. Arbitration, error signalling and retries are handled elsewhere.

The controlling state machine walks through these states:
- IDLE: waiting for start.
- BODY: unstuffed header and data bits.
- CRC: the 15 checksum bits.
- CRC_END: a possible last stuff bit, then the delimiter.
- DELIM, ACK, ACK_DELIM: the delimiter and acknowledge bits.
- EOF: seven end-of-frame bits.
- IFS: three intermission bits.

The transitions are:
- IDLE to BODY on an accepted start.
- BODY to CRC when the last body bit is sent.
- CRC to CRC_END after the fifteenth checksum bit.
- CRC_END to DELIM once no stuff bit is owed.
- DELIM to ACK, ACK to ACK_DELIM, and ACK_DELIM to EOF, each on one tick.
- EOF to IFS after seven bits.
- IFS to IDLE after three bits, which raises `done`.

Top module: `can_frame_tx`

## Requirements
- R1: While reset is held, and whenever the block is idle, `tx` is 1 (recessive), and `busy`, `done` and `ack_missing` are 0.
- R2: With `layout_ext`=0, the frame uses an 11-bit identifier. The identifier is byte0 (ID[10:3]) followed by byte1 bits 7:5 (ID[2:0]). RTR is byte1 bit 4, DLC is byte1 bits 3:0, and data bytes come from bytes 2..9. The bit order is SOF=0, ID MSB first, RTR, 0, 0, DLC MSB first, then data bytes MSB first.
- R3: With `layout_ext`=1 and byte0 bit 7 = 1, the frame uses a 29-bit identifier taken from {byte1, byte2, byte3, byte4[7:3]}. RTR is byte0 bit 6, DLC is byte0 bits 3:0, and data comes from bytes 5..12. The bit order is SOF, ID[28:18], 1, 1, ID[17:0], RTR, 0, 0, DLC, then data.
- R4: With `layout_ext`=1 and byte0 bit 7 = 0, an 11-bit-identifier frame is sent. Its identifier is ID[28:18] of the extended layout, and RTR, DLC and data are taken as in R3.
- R5: A frame with RTR=1 carries no data bits. A DLC above 8 sends 8 data bytes. The DLC field itself is always sent exactly as stored.
- R6: The CRC is the 15-bit polynomial 0x4599 with an initial value of 0. It covers the unstuffed bits from SOF to the end of the data and is sent MSB first.
- R7: After five equal consecutive bits, counting earlier stuff bits, one bit of the opposite level is inserted. This applies from SOF through the last CRC bit, including directly after the last CRC bit, and never later.
- R8: After the CRC and any final stuff bit, 13 recessive bits follow: the delimiter, the ACK slot, the ACK delimiter, 7 EOF bits and 3 intermission bits.
- R9: `tx` changes only in the cycle after a `bit_tick`, by one bit per tick. The first tick after an accepted start puts SOF on `tx`.
- R10: `busy` rises in the cycle after an accepted start. The tick that ends the last intermission bit gives a one-cycle `done` pulse, and `busy` is already 0 in that same cycle.
- R11: `bus_rx` is sampled on the tick that ends the ACK slot. If it reads 1, `ack_missing` is 1 from the `done` cycle until the next accepted start; otherwise it is 0.
- R12: A start pulse is ignored while `busy` is 1. The buffer and layout are captured at the accepted start, so later changes to them do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send the buffered frame |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| layout_ext | input | 1 | Selects the extended buffer layout |
| tx_buf | input | 104 | Buffer; byte k is at bits 8k+7:8k |
| bus_rx | input | 1 | Sampled bus level, used during the ACK slot |
| tx | output | 1 | Serial frame output, 1 = recessive |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ack_missing | output | 1 | No acknowledge was seen in the last frame |

## Verification
The hardest case to reach from the ports is a stuff bit owed immediately after the last CRC bit. Whether it occurs depends on the CRC value, which the ports do not control directly. To reach it, the bench runs its arithmetic frame model over all 2048 base identifiers with an empty data field. It picks an identifier whose stuffed stream ends its CRC on a run of five equal bits, then sends that frame and compares every bit. The other cases are covered by sweeping every DLC value with both RTR settings in each layout, and by using all-zero and all-one data to stress heavy stuffing.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BODY,
        ST_CRC,
        ST_CRC_END,
        ST_DELIM,
        ST_ACK,
        ST_ACK_DELIM,
        ST_EOF,
        ST_IFS
    } tx_state_e;

    localparam int BASE_HDR_BITS = 19;
    localparam int EXT_HDR_BITS  = 39;
    localparam int BASE_DATA0    = 2;
    localparam int EXT_DATA0     = 5;

endpackage

// File: rtl/can_tx_pack.sv
module can_tx_pack
    import can_tx_pkg::*;
#(
    parameter int MAX_DATA_BYTES = 8,
    localparam int BUF_BYTES = EXT_DATA0 + MAX_DATA_BYTES,
    localparam int DATA_BITS = 8 * MAX_DATA_BYTES,
    localparam int BODY_W    = EXT_HDR_BITS + DATA_BITS,
    localparam int LEN_W     = $clog2(BODY_W + 1)
) (
    input  logic                   layout_ext,
    input  logic [8*BUF_BYTES-1:0] tx_buf,
    output logic [BODY_W-1:0]      body,
    output logic [LEN_W-1:0]       body_len
);

    localparam int PAD_BITS = EXT_HDR_BITS - BASE_HDR_BITS;

    logic [7:0]           byt [BUF_BYTES];
    logic [28:0]          id_long;
    logic [10:0]          id_short;
    logic                 rtr;
    logic [3:0]           dlc;
    logic [3:0]           nbytes;
    logic                 long_fmt;
    logic [DATA_BITS-1:0] payload;
    logic                 unused_bits;

    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_bytes
        assign byt[g] = tx_buf[8*g +: 8];
    end

    assign unused_bits = &{byt[0][5:4], byt[4][2:0]};
    assign id_long     = {byt[1], byt[2], byt[3], byt[4][7:3]};
    assign long_fmt    = layout_ext & byt[0][7];

    always_comb begin
        if (layout_ext) begin
            rtr      = byt[0][6];
            dlc      = byt[0][3:0];
            id_short = id_long[28:18];
        end else begin
            rtr      = byt[1][4];
            dlc      = byt[1][3:0];
            id_short = {byt[0], byt[1][7:5]};
        end
        for (int k = 0; k < MAX_DATA_BYTES; k++) begin
            payload[DATA_BITS-1-8*k -: 8] = layout_ext ? byt[EXT_DATA0+k] : byt[BASE_DATA0+k];
        end
        if (rtr)
            nbytes = 4'd0;
        else if (dlc > 4'(MAX_DATA_BYTES))
            nbytes = 4'(MAX_DATA_BYTES);
        else
            nbytes = dlc;
    end

    always_comb begin
        if (long_fmt) begin
            body     = {1'b0, id_long[28:18], 2'b11, id_long[17:0], rtr, 2'b00, dlc, payload};
            body_len = LEN_W'(EXT_HDR_BITS) + LEN_W'({nbytes, 3'b000});
        end else begin
            body     = {1'b0, id_short, rtr, 2'b00, dlc, payload, {PAD_BITS{1'b0}}};
            body_len = LEN_W'(BASE_HDR_BITS) + LEN_W'({nbytes, 3'b000});
        end
    end

endmodule

// File: rtl/can_tx_crc.sv
module can_tx_crc #(
    parameter int          CRC_W    = 15,
    parameter logic [14:0] CRC_POLY = 15'h4599
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);

    logic feedback;
    assign feedback = bit_in ^ crc[CRC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY[CRC_W-1:0] : '0);
        end
    end

endmodule

// File: rtl/can_tx_stuff.sv
module can_tx_stuff #(
    parameter int STUFF_RUN = 5,
    localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    input  logic bit_in,
    output logic stuff_due,
    output logic stuff_bit
);

    logic             last_q;
    logic [RUN_W-1:0] run_q;

    assign stuff_due = (run_q == RUN_W'(STUFF_RUN));
    assign stuff_bit = ~last_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            last_q <= 1'b1;
            run_q  <= '0;
        end else if (adv) begin
            if (stuff_due) begin
                last_q <= ~last_q;
                run_q  <= RUN_W'(1);
            end else if (bit_in == last_q) begin
                run_q  <= run_q + RUN_W'(1);
            end else begin
                last_q <= bit_in;
                run_q  <= RUN_W'(1);
            end
        end
    end

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
    import can_tx_pkg::*;
#(
    parameter int          MAX_DATA_BYTES = 8,
    parameter int          STUFF_RUN      = 5,
    parameter int          EOF_BITS       = 7,
    parameter int          IFS_BITS       = 3,
    parameter logic [14:0] CRC_POLY       = 15'h4599,
    localparam int BUF_BYTES = EXT_DATA0 + MAX_DATA_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   bit_tick,
    input  logic                   layout_ext,
    input  logic [8*BUF_BYTES-1:0] tx_buf,
    input  logic                   bus_rx,
    output logic                   tx,
    output logic                   busy,
    output logic                   done,
    output logic                   ack_missing
);

    localparam int DATA_BITS = 8 * MAX_DATA_BYTES;
    localparam int BODY_W    = EXT_HDR_BITS + DATA_BITS;
    localparam int LEN_W     = $clog2(BODY_W + 1);
    localparam int CRC_W     = 15;
    localparam int CIDX_W    = $clog2(CRC_W);
    localparam int TCNT_W    = $clog2(EOF_BITS > IFS_BITS ? EOF_BITS : IFS_BITS);

    tx_state_e         state, state_n;
    logic [BODY_W-1:0] body_q, pack_body;
    logic [LEN_W-1:0]  remain_q, pack_len;
    logic [CIDX_W-1:0] cidx_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [CRC_W-1:0]  crc_val;
    logic              ack_pend_q;
    logic              accept, stuffed, step, data_bit, last_tick;
    logic              stuff_due, stuff_bit;

    can_tx_pack #(.MAX_DATA_BYTES(MAX_DATA_BYTES)) u_pack (
        .layout_ext (layout_ext),
        .tx_buf     (tx_buf),
        .body       (pack_body),
        .body_len   (pack_len)
    );

    assign accept    = start && (state == ST_IDLE);
    assign stuffed   = (state == ST_BODY) || (state == ST_CRC) || (state == ST_CRC_END);
    assign step      = bit_tick && stuffed && !stuff_due;
    assign last_tick = bit_tick && (state == ST_IFS) && (tcnt_q == TCNT_W'(IFS_BITS - 1));
    assign busy      = (state != ST_IDLE);

    always_comb begin
        unique case (state)
            ST_BODY: data_bit = body_q[BODY_W-1];
            ST_CRC:  data_bit = crc_val[CIDX_W'(CRC_W - 1) - cidx_q];
            default: data_bit = 1'b1;
        endcase
    end

    can_tx_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .en     (step && (state == ST_BODY)),
        .bit_in (data_bit),
        .crc    (crc_val)
    );

    can_tx_stuff #(.STUFF_RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .adv       (bit_tick && stuffed),
        .bit_in    (data_bit),
        .stuff_due (stuff_due),
        .stuff_bit (stuff_bit)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (accept) state_n = ST_BODY;
            ST_BODY:      if (step && remain_q == LEN_W'(1)) state_n = ST_CRC;
            ST_CRC:       if (step && cidx_q == CIDX_W'(CRC_W - 1)) state_n = ST_CRC_END;
            ST_CRC_END:   if (step) state_n = ST_DELIM;
            ST_DELIM:     if (bit_tick) state_n = ST_ACK;
            ST_ACK:       if (bit_tick) state_n = ST_ACK_DELIM;
            ST_ACK_DELIM: if (bit_tick) state_n = ST_EOF;
            ST_EOF:       if (bit_tick && tcnt_q == TCNT_W'(EOF_BITS - 1)) state_n = ST_IFS;
            ST_IFS:       if (last_tick) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            body_q   <= '0;
            remain_q <= '0;
            cidx_q   <= '0;
            tcnt_q   <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                body_q   <= pack_body;
                remain_q <= pack_len;
                cidx_q   <= '0;
                tcnt_q   <= '0;
            end
            if (step && state == ST_BODY) begin
                body_q   <= {body_q[BODY_W-2:0], 1'b0};
                remain_q <= remain_q - LEN_W'(1);
            end
            if (step && state == ST_CRC)
                cidx_q <= cidx_q + CIDX_W'(1);
            if (bit_tick && (state == ST_EOF || state == ST_IFS))
                tcnt_q <= (state_n != state) ? '0 : tcnt_q + TCNT_W'(1);
        end
    end

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx          <= 1'b1;
            done        <= 1'b0;
            ack_missing <= 1'b0;
            ack_pend_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                ack_missing <= 1'b0;
                ack_pend_q  <= 1'b0;
            end
            if (bit_tick && busy) begin
                if (stuffed && stuff_due)
                    tx <= stuff_bit;
                else if (state == ST_BODY || state == ST_CRC)
                    tx <= data_bit;
                else
                    tx <= 1'b1;
                if (state == ST_ACK)
                    ack_pend_q <= bus_rx;
                if (last_tick) begin
                    done        <= 1'b1;
                    ack_missing <= ack_pend_q;
                end
            end
        end
    end

endmodule

// File: rtl/can_frame_tx_chk.sv
module can_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bit_tick,
    input logic tx,
    input logic busy,
    input logic done,
    input logic ack_missing
);

    a_r9_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(tx));

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_tick));

    a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    a_r12_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r11_flag_changes: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_missing != $past(ack_missing)) |-> (done || $past(start && !busy)));

endmodule

bind can_frame_tx can_frame_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bit_tick    (bit_tick),
    .tx          (tx),
    .busy        (busy),
    .done        (done),
    .ack_missing (ack_missing)
);

// File: tb/tb_can_frame_tx.sv
module tb_can_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 13;

    logic               clk = 1'b0;
    logic               rst_n, start, bit_tick, layout_ext, bus_rx;
    logic [8*NBYTES-1:0] tx_buf;
    logic               tx, busy, done, ack_missing;
    logic [7:0]         bb [NBYTES];

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic ub [0:199];
    int   ul;
    logic ex [0:299];
    int   el;
    bit   tail_stuff;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int g = 0; g < NBYTES; g++) tx_buf[8*g +: 8] = bb[g];
    end

    can_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
        .layout_ext(layout_ext), .tx_buf(tx_buf), .bus_rx(bus_rx),
        .tx(tx), .busy(busy), .done(done), .ack_missing(ack_missing)
    );

    task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic push_u(input logic b);
        ub[ul] = b;
        ul++;
    endtask

    task automatic push_e(input logic b);
        ex[el] = b;
        el++;
    endtask

    // Arithmetic frame model built from the requirements
    task automatic build_exp(input bit lay);
        bit          is_ext, rtr;
        logic [3:0]  dl;
        logic [28:0] id;
        logic [14:0] c;
        int          nb, dbase, cnt;
        logic        prev, fb;
        ul = 0;
        el = 0;
        tail_stuff = 0;
        if (lay) begin
            is_ext = bb[0][7]; rtr = bb[0][6]; dl = bb[0][3:0];
            id = {bb[1], bb[2], bb[3], bb[4][7:3]}; dbase = 5;
            if (!is_ext) id = id >> 18;
        end else begin
            is_ext = 0; rtr = bb[1][4]; dl = bb[1][3:0];
            id = {18'd0, bb[0], bb[1][7:5]}; dbase = 2;
        end
        push_u(1'b0);
        if (is_ext) begin
            for (int i = 28; i >= 18; i--) push_u(id[i]);
            push_u(1'b1); push_u(1'b1);
            for (int i = 17; i >= 0; i--) push_u(id[i]);
        end else begin
            for (int i = 10; i >= 0; i--) push_u(id[i]);
        end
        push_u(rtr); push_u(1'b0); push_u(1'b0);
        for (int i = 3; i >= 0; i--) push_u(dl[i]);
        nb = rtr ? 0 : ((dl > 8) ? 8 : int'(dl));
        for (int j = 0; j < nb; j++)
            for (int i = 7; i >= 0; i--) push_u(bb[dbase+j][i]);
        c = '0;
        for (int n = 0; n < ul; n++) begin
            fb = ub[n] ^ c[14];
            c = {c[13:0], 1'b0};
            if (fb) c = c ^ 15'h4599;
        end
        for (int i = 14; i >= 0; i--) push_u(c[i]);
        cnt = 0;
        prev = 1'b1;
        for (int n = 0; n < ul; n++) begin
            push_e(ub[n]);
            if (n > 0 && ub[n] == prev) cnt++; else cnt = 1;
            prev = ub[n];
            if (cnt == 5) begin
                if (n == ul - 1) tail_stuff = 1;
                push_e(~prev);
                prev = ~prev;
                cnt = 1;
            end
        end
        for (int i = 0; i < 13; i++) push_e(1'b1);
    endtask

    task automatic run_frame(input bit lay, input bit ackr, input bit poke, input string tag);
        logic [7:0] saved [NBYTES];
        int   mism = 0, first = -1, unstable = 0, early = 0;
        logic hold, d1 = 0, d2 = 0, b1 = 1, firstv = 0;
        layout_ext = lay;
        build_exp(lay);
        bus_rx = ackr;
        for (int g = 0; g < NBYTES; g++) saved[g] = bb[g];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1 && tx == 1'b1, "R10", "busy after start, tx still idle", int'({busy, tx}), 3);
        for (int k = 0; k <= el; k++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            if (k < el) begin
                if (tx !== ex[k]) begin
                    if (first < 0) begin first = k; firstv = tx; end
                    mism++;
                end
                if (done) early++;
            end else begin
                d1 = done; b1 = busy;
            end
            hold = tx;
            @(negedge clk);
            if (tx !== hold) unstable++;
            if (k == el) d2 = done;
            if (poke && k == 20) begin
                for (int g = 0; g < NBYTES; g++) bb[g] = ~bb[g];
                layout_ext = ~lay;
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        end
        check(mism == 0, tag, $sformatf("bit stream, first bad index %0d", first),
              int'(firstv), (first >= 0) ? int'(ex[first]) : 0);
        check(early == 0, "R10", "done before last tick", early, 0);
        check(unstable == 0, "R9", "tx moved without tick", unstable, 0);
        check(d1 == 1'b1 && b1 == 1'b0, "R10", "done high, busy low at end", int'({d1, b1}), 2);
        check(d2 == 1'b0, "R10", "done lasts one cycle", int'(d2), 0);
        check(ack_missing == ackr, "R11", "ack_missing", int'(ack_missing), int'(ackr));
        for (int g = 0; g < NBYTES; g++) bb[g] = saved[g];
        layout_ext = lay;
        repeat (2) @(negedge clk);
        check(tx == 1'b1 && ack_missing == ackr, "R1", "idle tx and held flag", int'({tx, ack_missing}), int'({1'b1, ackr}));
    endtask

    task automatic fill_data(input int seed);
        for (int g = 2; g < NBYTES; g++) bb[g] = 8'((g * 37 + seed * 11) & 8'hff);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; bit_tick = 1'b0; layout_ext = 1'b0; bus_rx = 1'b1;
        for (int g = 0; g < NBYTES; g++) bb[g] = 8'h00;
        repeat (3) @(negedge clk);
        check(tx == 1'b1 && busy == 1'b0 && done == 1'b0 && ack_missing == 1'b0, "R1", "reset outputs",
              int'({tx, busy, done, ack_missing}), 8);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 example buffer: ID[10:3]=0x55, ID[2:0]=2, RTR=1, DLC=7
        bb[0] = 8'h55; bb[1] = 8'h57; fill_data(1);
        run_frame(1'b0, 1'b0, 1'b0, "R2");

        // R2 / R5 sweep: every DLC, both RTR values, base layout
        for (int d = 0; d < 16; d++) begin
            for (int r = 0; r < 2; r++) begin
                bb[0] = 8'(8'h55 ^ (d * 17));
                bb[1] = {3'(d), 1'(r), 4'(d)};
                fill_data(d + r);
                run_frame(1'b0, 1'((d + r) & 1), 1'b0, (r == 1 || d > 8) ? "R5" : "R2");
            end
        end

        // R3 example: extended, remote, DLC 5
        bb[0] = 8'hC5; bb[1] = 8'hA6; bb[2] = 8'h00; bb[3] = 8'h5A; bb[4] = 8'hA8;
        run_frame(1'b1, 1'b0, 1'b0, "R3");

        // R3 / R5 sweep: extended layout, every DLC, both RTR values
        for (int d = 0; d < 16; d++) begin
            for (int r = 0; r < 2; r++) begin
                fill_data(d * 3 + r);
                bb[0] = {1'b1, 1'(r), 2'b00, 4'(d)};
                bb[1] = 8'(d * 29); bb[2] = 8'hC3 ^ 8'(r); bb[3] = 8'(d); bb[4] = 8'(8'hF8 ^ (d << 3));
                run_frame(1'b1, 1'(d & 1), 1'b0, (r == 1 || d > 8) ? "R5" : "R3");
            end
        end

        // R4: extended layout with the format flag cleared
        for (int d = 0; d < 4; d++) begin
            fill_data(d + 40);
            bb[0] = {1'b0, 1'(d == 3), 2'b11, 4'(d * 3)};
            bb[4] = 8'h07;
            run_frame(1'b1, 1'b0, 1'b0, "R4");
        end

        // R7: heavy stuffing with all-zero and all-one content
        for (int g = 0; g < NBYTES; g++) bb[g] = 8'h00;
        bb[1] = 8'h08;
        run_frame(1'b0, 1'b0, 1'b0, "R7");
        for (int g = 0; g < NBYTES; g++) bb[g] = 8'hFF;
        bb[1] = 8'hE8;
        run_frame(1'b0, 1'b0, 1'b0, "R7");

        // R7: stuff bit owed right after the last CRC bit
        begin
            bit found = 0;
            for (int id = 0; id < 2048 && !found; id++) begin
                bb[0] = 8'(id >> 3);
                bb[1] = {3'(id), 5'd0};
                build_exp(1'b0);
                if (tail_stuff) found = 1;
            end
            check(found, "R7", "tail stuff case found", int'(found), 1);
            if (found) run_frame(1'b0, 1'b0, 1'b0, "R7");
        end

        // R6 / R8: checksum and tail on a full data frame
        bb[0] = 8'h12; bb[1] = 8'h68; fill_data(7);
        run_frame(1'b0, 1'b0, 1'b0, "R6");
        run_frame(1'b0, 1'b1, 1'b0, "R8");

        // R12: start and buffer changes while busy are ignored
        bb[0] = 8'hB7; bb[1] = 8'hA4; fill_data(9);
        run_frame(1'b0, 1'b1, 1'b1, "R12");
        bb[0] = 8'h88; bb[1] = 8'h10; bb[2] = 8'h33; bb[3] = 8'h00; bb[4] = 8'hF0;
        run_frame(1'b1, 1'b0, 1'b1, "R12");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule